// File: doc/BRIEF.md
# LCD Raster Timing Generator

This block produces the scan timing for a parallel display panel. A system clock is divided down to a pixel-clock enable. A horizontal and a vertical segment sequencer then step through sync, back margin, active area and front margin. From that the block derives the line sync, frame sync, data-enable, a pixel clock pin and the current pixel coordinates. An upstream pixel source watches the data-valid strobe and the coordinates to know which pixel to present next.

Passive-matrix panels also need an AC-bias signal that flips polarity every few lines, so the block provides one at a programmable line rate. Polarity of both syncs, polarity of data-enable and the pixel clock edge on which data changes are selected by a four-bit configuration word. All timing and configuration inputs are captured into shadow registers only on the first cycle after reset and at each frame boundary, so software may rewrite them at any time without tearing a frame.

Each axis is one sequencer `lcd_axis` with four states: `SEG_SYNC`, `SEG_BACK`, `SEG_ACTIVE`, `SEG_FRONT`. On a step taken in the last unit of a state it moves SYNC→BACK (sync done), BACK→ACTIVE (back margin done), ACTIVE→FRONT (active area done) and FRONT→SYNC (wrap: end of line or end of frame). Otherwise a step advances the unit counter within the state. The horizontal axis steps on every pixel enable. The vertical axis steps on the horizontal wrap.

Top module: `lcd_raster_gen`

## Requirements
- R1: `pix_ce` is high for one clock in every CLK_DIV clocks (CLK_DIV ≥ 2). `pclk_out` is high in the cycle where `pix_ce` is high and low in the cycle after it, both inverted when `cfg_word` bit 3 is 1. Bit 3 set means data changes on the falling pixel edge.
- R2: Each line is `h_sync_len` pixels of sync, then `h_back_len` pixels of back margin, then `h_active` active pixels, then `h_front_len` pixels of front margin, with every length of 0 acting as 1.
- R3: Each frame is `v_sync_len` lines of sync, then `v_back_len`, then `v_active`, then `v_front_len` lines, with every length of 0 acting as 1.
- R4: `hsync` is high during horizontal sync pixels, and `vsync` is high during vertical sync lines. Each is inverted when its `cfg_word` bit is 1: bit 0 for line sync, bit 1 for frame sync.
- R5: `pix_valid` is high exactly when both axes are in their active segment, giving active-width × active-height strobes per frame. `de_out` equals `pix_valid`, inverted when `cfg_word` bit 2 is 1.
- R6: While `pix_valid` is high, `pix_x` and `pix_y` give the zero-based column and row within the active area.
- R7: For panel types other than 5, `ac_bias` toggles at every (`bias_rate`+1)-th line wrap, counted from reset, and starts low.
- R8: When `panel_type` is 5 (active matrix), `ac_bias` is held low and its line count is cleared.
- R9: All timing, rate, type and configuration inputs take effect only from the first pixel of the frame after the one in which they changed.
- R10: During reset `pix_ce`, `pix_valid`, `ac_bias`, `pix_x` and `pix_y` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_active | input | W | Active pixels per line |
| v_active | input | W | Active lines per frame |
| h_sync_len | input | MW | Line sync length in pixels |
| h_back_len | input | MW | Margin between line sync and active pixels |
| h_front_len | input | MW | Margin after active pixels |
| v_sync_len | input | MW | Frame sync length in lines |
| v_back_len | input | MW | Lines between frame sync and active lines |
| v_front_len | input | MW | Lines after the active lines |
| bias_rate | input | RW | AC-bias toggles every bias_rate+1 lines |
| panel_type | input | 4 | Panel kind: 0 unknown, 1–4 passive kinds, 5 active matrix |
| cfg_word | input | 4 | Bit0 line sync low, bit1 frame sync low, bit2 data-enable low, bit3 falling-edge data |
| pix_ce | output | 1 | Pixel clock enable |
| pclk_out | output | 1 | Pixel clock pin |
| hsync | output | 1 | Line sync pin |
| vsync | output | 1 | Frame sync pin |
| de_out | output | 1 | Data-enable pin |
| ac_bias | output | 1 | AC-bias pin for passive panels |
| pix_valid | output | 1 | Active-pixel strobe, active high |
| pix_x | output | W | Active column |
| pix_y | output | W | Active row |

## Verification
The last pixel of a frame is where three effects meet in one clock. The line wrap advances the AC-bias count, the frame wrap resets both sequencers, and the shadow registers reload. The bench provokes this by rewriting timing, polarity, rate and panel type halfway through a frame, with a bias rate of 0 so that the bias toggles on that very wrap. It judges the result pixel by pixel against a model that first updates the bias from the old shadow values and only then loads the new ones, so a design that reloads too early or applies the new rate to the final wrap shows a mismatch in the first lines of the next frame.

// File: rtl/lcd_raster_pkg.sv
package lcd_raster_pkg;

    typedef enum logic [1:0] {
        SEG_SYNC   = 2'd0,
        SEG_BACK   = 2'd1,
        SEG_ACTIVE = 2'd2,
        SEG_FRONT  = 2'd3
    } seg_e;

    localparam logic [3:0] PANEL_ACTIVE_MATRIX = 4'd5;

    localparam int CFG_HS_LOW    = 0;
    localparam int CFG_VS_LOW    = 1;
    localparam int CFG_DE_LOW    = 2;
    localparam int CFG_PCLK_FALL = 3;

endpackage

// File: rtl/lcd_axis.sv
module lcd_axis
    import lcd_raster_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] len_sync,
    input  logic [W-1:0] len_back,
    input  logic [W-1:0] len_act,
    input  logic [W-1:0] len_front,
    output seg_e         seg,
    output logic [W-1:0] pos,
    output logic         wrap
);

    seg_e         seg_q, seg_d;
    logic [W-1:0] cnt_q, cnt_d;
    logic [W-1:0] seg_len, last_idx;
    logic         at_end;

    always_comb begin
        seg_len = '0;
        unique case (seg_q)
            SEG_SYNC:   seg_len = len_sync;
            SEG_BACK:   seg_len = len_back;
            SEG_ACTIVE: seg_len = len_act;
            SEG_FRONT:  seg_len = len_front;
        endcase
        last_idx = (seg_len == '0) ? '0 : seg_len - W'(1);
        at_end   = (cnt_q == last_idx);

        seg_d = seg_q;
        cnt_d = cnt_q;
        if (step) begin
            if (at_end) begin
                cnt_d = '0;
                unique case (seg_q)
                    SEG_SYNC:   seg_d = SEG_BACK;
                    SEG_BACK:   seg_d = SEG_ACTIVE;
                    SEG_ACTIVE: seg_d = SEG_FRONT;
                    SEG_FRONT:  seg_d = SEG_SYNC;
                endcase
            end else begin
                cnt_d = cnt_q + W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q <= SEG_SYNC;
            cnt_q <= '0;
        end else begin
            seg_q <= seg_d;
            cnt_q <= cnt_d;
        end
    end

    assign seg  = seg_q;
    assign pos  = cnt_q;
    assign wrap = (seg_q == SEG_FRONT) && at_end;

endmodule

// File: rtl/lcd_bias.sv
module lcd_bias #(
    parameter int RW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          hold,
    input  logic [RW-1:0] rate,
    output logic          bias_q
);

    logic [RW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bias_q <= 1'b0;
        end else if (tick) begin
            if (hold) begin
                cnt_q  <= '0;
                bias_q <= 1'b0;
            end else if (cnt_q == rate) begin
                cnt_q  <= '0;
                bias_q <= ~bias_q;
            end else begin
                cnt_q <= cnt_q + RW'(1);
            end
        end
    end

endmodule

// File: rtl/lcd_raster_gen.sv
module lcd_raster_gen
    import lcd_raster_pkg::*;
#(
    parameter int CLK_DIV = 2,
    parameter int W       = 16,
    parameter int MW      = 8,
    parameter int RW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  h_active,
    input  logic [W-1:0]  v_active,
    input  logic [MW-1:0] h_sync_len,
    input  logic [MW-1:0] h_back_len,
    input  logic [MW-1:0] h_front_len,
    input  logic [MW-1:0] v_sync_len,
    input  logic [MW-1:0] v_back_len,
    input  logic [MW-1:0] v_front_len,
    input  logic [RW-1:0] bias_rate,
    input  logic [3:0]    panel_type,
    input  logic [3:0]    cfg_word,
    output logic          pix_ce,
    output logic          pclk_out,
    output logic          hsync,
    output logic          vsync,
    output logic          de_out,
    output logic          ac_bias,
    output logic          pix_valid,
    output logic [W-1:0]  pix_x,
    output logic [W-1:0]  pix_y
);

    localparam int            DW       = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST = DW'(CLK_DIV - 1);
    localparam logic [DW-1:0] DIV_HALF = DW'(CLK_DIV / 2);

    logic          fresh;
    logic [DW-1:0] div_q;
    logic          shadow_load, line_tick, frame_end;

    logic [W-1:0]  sh_hact, sh_vact;
    logic [MW-1:0] sh_hs, sh_hb, sh_hf, sh_vs, sh_vb, sh_vf;
    logic [RW-1:0] sh_rate;
    logic [3:0]    sh_type, sh_cfg;

    seg_e          h_seg, v_seg;
    logic [W-1:0]  h_pos, v_pos;
    logic          h_wrap, v_wrap;
    logic          bias_q, bias_hold, in_active;

    // pixel-rate divider; idle during the capture cycle after reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh <= 1'b1;
            div_q <= '0;
        end else begin
            fresh <= 1'b0;
            if (!fresh)
                div_q <= (div_q == DIV_LAST) ? '0 : div_q + DW'(1);
        end
    end

    assign pix_ce      = !fresh && (div_q == DIV_LAST);
    assign line_tick   = pix_ce && h_wrap;
    assign frame_end   = line_tick && v_wrap;
    assign shadow_load = fresh || frame_end;

    // frame-boundary capture of all programmable inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_hact <= '0; sh_vact <= '0;
            sh_hs   <= '0; sh_hb   <= '0; sh_hf <= '0;
            sh_vs   <= '0; sh_vb   <= '0; sh_vf <= '0;
            sh_rate <= '0; sh_type <= '0; sh_cfg <= '0;
        end else if (shadow_load) begin
            sh_hact <= h_active;   sh_vact <= v_active;
            sh_hs   <= h_sync_len; sh_hb   <= h_back_len; sh_hf <= h_front_len;
            sh_vs   <= v_sync_len; sh_vb   <= v_back_len; sh_vf <= v_front_len;
            sh_rate <= bias_rate;  sh_type <= panel_type; sh_cfg <= cfg_word;
        end
    end

    lcd_axis #(.W(W)) i_h_axis (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (pix_ce),
        .len_sync  (W'(sh_hs)),
        .len_back  (W'(sh_hb)),
        .len_act   (sh_hact),
        .len_front (W'(sh_hf)),
        .seg       (h_seg),
        .pos       (h_pos),
        .wrap      (h_wrap)
    );

    lcd_axis #(.W(W)) i_v_axis (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (line_tick),
        .len_sync  (W'(sh_vs)),
        .len_back  (W'(sh_vb)),
        .len_act   (sh_vact),
        .len_front (W'(sh_vf)),
        .seg       (v_seg),
        .pos       (v_pos),
        .wrap      (v_wrap)
    );

    assign bias_hold = (sh_type == PANEL_ACTIVE_MATRIX);

    lcd_bias #(.RW(RW)) i_bias (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (line_tick),
        .hold   (bias_hold),
        .rate   (sh_rate),
        .bias_q (bias_q)
    );

    // output decode
    always_comb begin
        in_active = (h_seg == SEG_ACTIVE) && (v_seg == SEG_ACTIVE);
        pix_valid = in_active;
        de_out    = in_active ^ sh_cfg[CFG_DE_LOW];
        hsync     = (h_seg == SEG_SYNC) ^ sh_cfg[CFG_HS_LOW];
        vsync     = (v_seg == SEG_SYNC) ^ sh_cfg[CFG_VS_LOW];
        pix_x     = (h_seg == SEG_ACTIVE) ? h_pos : '0;
        pix_y     = (v_seg == SEG_ACTIVE) ? v_pos : '0;
        pclk_out  = (div_q >= DIV_HALF) ^ sh_cfg[CFG_PCLK_FALL];
        ac_bias   = bias_q && !bias_hold;
    end

endmodule

// File: rtl/lcd_raster_chk.sv
module lcd_raster_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pix_ce,
    input logic         pix_valid,
    input logic [W-1:0] pix_x,
    input logic [W-1:0] pix_y,
    input logic         hsync,
    input logic         vsync,
    input logic         ac_bias,
    input logic         line_tick,
    input logic         load
);

    p_ce_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ce |=> !pix_ce);

    p_hold_between_ce_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_ce && !load) |=> ($stable(hsync) && $stable(vsync) &&
                                $stable(pix_x) && $stable(pix_y) && $stable(ac_bias)));

    p_x_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid) && $past(pix_ce)) |-> (pix_x == $past(pix_x) + W'(1)));

    p_y_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid)) |-> (pix_y == $past(pix_y)));

    p_bias_on_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ac_bias) |-> ($past(line_tick) || $past(load)));

endmodule

bind lcd_raster_gen lcd_raster_chk #(.W(W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_ce    (pix_ce),
    .pix_valid (pix_valid),
    .pix_x     (pix_x),
    .pix_y     (pix_y),
    .hsync     (hsync),
    .vsync     (vsync),
    .ac_bias   (ac_bias),
    .line_tick (line_tick),
    .load      (shadow_load)
);

// File: tb/test_lcd_raster_gen.sv
module test_lcd_raster_gen;

    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] h_active, v_active;
    logic [7:0]  h_sync_len, h_back_len, h_front_len;
    logic [7:0]  v_sync_len, v_back_len, v_front_len;
    logic [7:0]  bias_rate;
    logic [3:0]  panel_type, cfg_word;
    logic        pix_ce, pclk_out, hsync, vsync, de_out, ac_bias, pix_valid;
    logic [15:0] pix_x, pix_y;

    always #5 clk = ~clk;

    lcd_raster_gen #(.CLK_DIV(DIV)) i_lcd_raster_gen (
        .clk(clk), .rst_n(rst_n),
        .h_active(h_active), .v_active(v_active),
        .h_sync_len(h_sync_len), .h_back_len(h_back_len), .h_front_len(h_front_len),
        .v_sync_len(v_sync_len), .v_back_len(v_back_len), .v_front_len(v_front_len),
        .bias_rate(bias_rate), .panel_type(panel_type), .cfg_word(cfg_word),
        .pix_ce(pix_ce), .pclk_out(pclk_out), .hsync(hsync), .vsync(vsync),
        .de_out(de_out), .ac_bias(ac_bias), .pix_valid(pix_valid),
        .pix_x(pix_x), .pix_y(pix_y)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // reference model state
    int m_hs, m_hb, m_ha, m_hf, m_vs, m_vb, m_va, m_vf, m_rate, m_type, m_cfg;
    int hx, vy, bcnt, since_ce, frames, valid_cnt;
    bit bq, m_init, mon_on, prev_ce, saw_bias;

    function automatic int g(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    task automatic load_model();
        m_hs = h_sync_len; m_hb = h_back_len; m_ha = h_active; m_hf = h_front_len;
        m_vs = v_sync_len; m_vb = v_back_len; m_va = v_active; m_vf = v_front_len;
        m_rate = bias_rate; m_type = panel_type; m_cfg = cfg_word;
    endtask

    always @(negedge clk) begin
        if (mon_on && rst_n) begin
            since_ce++;
            if (pix_ce) begin
                int h0, v0, ht, vt;
                bit hact, vact, e_hs, e_vs, e_de, e_bias;
                if (m_init) begin
                    load_model();
                    hx = 0; vy = 0; bcnt = 0; bq = 0; m_init = 0;
                end else begin
                    chk(since_ce == DIV, "R1", "pix_ce spacing", since_ce, DIV);
                end
                since_ce = 0;
                h0 = g(m_hs) + g(m_hb);
                v0 = g(m_vs) + g(m_vb);
                ht = h0 + g(m_ha) + g(m_hf);
                vt = v0 + g(m_va) + g(m_vf);
                hact = (hx >= h0) && (hx < h0 + g(m_ha));
                vact = (vy >= v0) && (vy < v0 + g(m_va));
                e_hs = (hx < g(m_hs)) ^ m_cfg[0];
                e_vs = (vy < g(m_vs)) ^ m_cfg[1];
                e_de = (hact && vact) ^ m_cfg[2];
                e_bias = bq && (m_type != 5);
                chk(hsync == e_hs, "R2/R4", "hsync", hsync, e_hs);
                chk(vsync == e_vs, "R3/R4", "vsync", vsync, e_vs);
                chk(pix_valid == (hact && vact), "R5", "pix_valid", pix_valid, hact && vact);
                chk(de_out == e_de, "R5", "de_out", de_out, e_de);
                chk(ac_bias == e_bias, "R7/R8", "ac_bias", ac_bias, e_bias);
                chk(pclk_out == (1'b1 ^ m_cfg[3]), "R1", "pclk_out at ce", pclk_out, 1 ^ m_cfg[3]);
                if (ac_bias) saw_bias = 1;
                if (hact && vact) begin
                    valid_cnt++;
                    chk(pix_x == hx - h0, "R6", "pix_x", pix_x, hx - h0);
                    chk(pix_y == vy - v0, "R6", "pix_y", pix_y, vy - v0);
                end
                hx++;
                if (hx == ht) begin
                    hx = 0;
                    if (m_type == 5) begin
                        bq = 0; bcnt = 0;
                    end else if (bcnt == m_rate) begin
                        bq = !bq; bcnt = 0;
                    end else begin
                        bcnt++;
                    end
                    vy++;
                    if (vy == vt) begin
                        vy = 0;
                        chk(valid_cnt == g(m_ha) * g(m_va), "R5", "strobes per frame",
                            valid_cnt, g(m_ha) * g(m_va));
                        valid_cnt = 0;
                        frames++;
                        load_model();
                    end
                end
            end else if (prev_ce) begin
                chk(pclk_out == (1'b0 ^ m_cfg[3]), "R1", "pclk_out after ce",
                    pclk_out, 0 ^ m_cfg[3]);
            end
            prev_ce = pix_ce;
        end
    end

    task automatic set_cfg(input int hs, input int hb, input int ha, input int hf,
                           input int vs, input int vb, input int va, input int vf,
                           input int rate, input int ptype, input int cfg);
        h_sync_len = 8'(hs); h_back_len = 8'(hb); h_active = 16'(ha); h_front_len = 8'(hf);
        v_sync_len = 8'(vs); v_back_len = 8'(vb); v_active = 16'(va); v_front_len = 8'(vf);
        bias_rate = 8'(rate); panel_type = 4'(ptype); cfg_word = 4'(cfg);
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        mon_on = 0;
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        m_init = 1; prev_ce = 0; since_ce = 0; valid_cnt = 0; saw_bias = 0;
        mon_on = 1;
        rst_n = 1;
    endtask

    task automatic wait_frames(input int n);
        int target;
        target = frames + n;
        while (frames < target) @(negedge clk);
    endtask

    task automatic t_reset();
        set_cfg(2, 3, 8, 2, 1, 2, 4, 1, 0, 1, 0);
        @(posedge clk); #1;
        rst_n = 0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(pix_ce == 0, "R10", "pix_ce in reset", pix_ce, 0);
        chk(pix_valid == 0, "R10", "pix_valid in reset", pix_valid, 0);
        chk(ac_bias == 0, "R10", "ac_bias in reset", ac_bias, 0);
        chk(pix_x == 0 && pix_y == 0, "R10", "coords in reset", pix_x + pix_y, 0);
    endtask

    task automatic t_basic_passive();
        set_cfg(2, 3, 8, 2, 1, 2, 4, 1, 0, 1, 0);
        do_reset();
        wait_frames(2);
        chk(saw_bias == 1, "R7", "bias toggled on passive panel", saw_bias, 1);
    endtask

    task automatic t_polarity_rate();
        set_cfg(3, 1, 5, 4, 2, 1, 3, 2, 2, 3, 15);
        do_reset();
        wait_frames(3);
        chk(saw_bias == 1, "R7", "bias toggled at rate 2", saw_bias, 1);
    endtask

    task automatic t_zero_len_tft();
        set_cfg(1, 0, 0, 0, 0, 1, 0, 2, 0, 5, 4);
        do_reset();
        wait_frames(3);
        chk(saw_bias == 0, "R8", "bias held low on active matrix", saw_bias, 0);
    endtask

    task automatic t_midframe_change();
        int start;
        set_cfg(2, 3, 6, 2, 1, 2, 4, 1, 0, 2, 0);
        do_reset();
        start = frames;
        repeat (120) @(posedge clk);
        #1;
        set_cfg(1, 1, 4, 3, 2, 1, 3, 1, 1, 5, 11);
        wait_frames(1);
        chk(frames == start + 1, "R9", "first frame completed on old timing", frames, start + 1);
        set_cfg(4, 2, 7, 1, 1, 1, 2, 2, 0, 4, 2);
        wait_frames(2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        mon_on = 0; m_init = 0; frames = 0; bq = 0; bcnt = 0;
        hx = 0; vy = 0; since_ce = 0; prev_ce = 0; valid_cnt = 0; saw_bias = 0;
        t_reset();
        t_basic_passive();
        t_polarity_rate();
        t_zero_len_tft();
        t_midframe_change();
        @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule